// File: doc/BRIEF.md
# VME Slave Window Decoder

This block checks each incoming VMEbus slave cycle against three programmable address windows, one each for the 64-bit, 32-bit and 24-bit address spaces. When the cycle falls inside an enabled window, the block selects local memory and gives the offset of the access inside that window. The address modifier picks the address space. A per-window protection setting can refuse writes, or all accesses, and a refused access is flagged and never selected. There is no window for the 16-bit short address space.

The window settings come in as static configuration pins from a register file. The bus front end presents the address, the address modifier and the access kind with a one-cycle `cycleValid` strobe. One clock later the block returns a registered response that the memory controller and the bus handshake logic consume. Bus timing, memory control, parity and interrupts are handled elsewhere.

Top module: `vme_slave_win_dec`

## Requirements
- R1: A response is returned exactly one cycle after `cycleValid`: `respValid` is high for that one cycle only. While `cycleValid` is low, `winSel`, `hit`, `localOffset` and `protFault` keep their last values.
- R2: The address modifier picks the space. Code 0x00 is the 64-bit multiplexed block transfer. Codes 0x08 to 0x0F are the 32-bit space and codes 0x38 to 0x3F are the 24-bit space, both covering supervisory and non-privileged modes. Every other code, including the other 64-bit cycle types 0x01 and 0x03, hits nothing.
- R3: The 64-bit window covers a fixed 128 MB starting at `{a64BaseHi, 32'b0}`, so it starts on a 4 GB boundary. Only code 0x00 can hit it.
- R4: The 32-bit window starts at `{a32BaseHi, 27'b0}` and is 2^`a32SizeLog` bytes long. The size code is clamped to the range 12 to 27 (4 KB to 128 MB). Address bits above bit 31 are ignored.
- R5: The 24-bit window is 2^(19+`a24SizeSel`) bytes long (512 KB, 1 MB, 2 MB or 4 MB). Its start is `{a24BaseHi, 19'b0}` rounded down to a multiple of the window size. Address bits above bit 23 are ignored.
- R6: `localOffset` is the cycle address minus the start of the selected window. It is zero when nothing is selected.
- R7: Protection code 0 allows every access. Code 1 refuses write (`accType`=1), read-modify-write (2) and reserved (3) cycles but allows reads (0). Codes 2 and 3 refuse every access. A refused access gives `protFault`=1 with `winSel`=0 and `hit`=0.
- R8: A window whose enable pin is low never hits and never faults.
- R9: `winSel` is one-hot or zero (bit 0 = 24-bit window, bit 1 = 32-bit, bit 2 = 64-bit), and `hit` equals the OR of its bits. If several windows qualify, priority goes to the 64-bit window, then the 32-bit, then the 24-bit.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleValid | input | 1 | One-cycle strobe: the address, modifier and access kind are valid |
| vmeAddr | input | 64 | Cycle address |
| vmeAm | input | 6 | Address modifier code |
| accType | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 reserved |
| a64En | input | 1 | 64-bit window enable |
| a64BaseHi | input | 32 | 64-bit window start, address bits 63:32 |
| a64Prot | input | 2 | 64-bit window protection code |
| a32En | input | 1 | 32-bit window enable |
| a32BaseHi | input | 5 | 32-bit window start, address bits 31:27 |
| a32SizeLog | input | 5 | log2 of the 32-bit window size |
| a32Prot | input | 2 | 32-bit window protection code |
| a24En | input | 1 | 24-bit window enable |
| a24BaseHi | input | 5 | 24-bit window start, address bits 23:19 |
| a24SizeSel | input | 2 | 24-bit window size select |
| a24Prot | input | 2 | 24-bit window protection code |
| respValid | output | 1 | Response strobe |
| hit | output | 1 | Local memory selected |
| winSel | output | 3 | One-hot selected window |
| localOffset | output | 27 | Offset inside the selected window |
| protFault | output | 1 | Access refused by protection |

## Verification
The bench walks the edges of every window: one byte below the start, the first byte, the last byte and one byte past the end. It does this for every 24-bit size and base and for every 32-bit size code, including codes outside the clamp range. An off-by-one in the size mask shows up as a hit just outside the window or a miss on its last byte. A 24-bit decoder that uses the raw base instead of the rounded one misses or shifts the larger windows. All 64 modifier codes are swept with an address that lies inside all three windows. A decoder that lets a non-block 64-bit cycle through, or that misreads a space range, selects the wrong window. Every protection code is tried with every access kind, and a wrong mapping shows up as a missing or spurious fault. Disabled windows are checked to stay silent.

// File: rtl/vme_win_pkg.sv
package vme_win_pkg;

  localparam int NWIN    = 3;
  localparam int WIN_A24 = 0;
  localparam int WIN_A32 = 1;
  localparam int WIN_A64 = 2;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] PROT_NONE = 2'd0;
  localparam logic [1:0] PROT_WR   = 2'd1;

  localparam logic [5:0] AM_A64_BLK = 6'h00;
  localparam logic [2:0] AM_A32_GRP = 3'b001;
  localparam logic [2:0] AM_A24_GRP = 3'b111;

  typedef struct packed {
    logic            capture;
    logic [NWIN-1:0] sel;
    logic            fault;
  } win_strb_t;

endpackage

// File: rtl/vme_win_ctrl.sv
module vme_win_ctrl
  import vme_win_pkg::*;
(
  input  logic                 cycleValid,
  input  logic [5:0]           vmeAm,
  input  logic [1:0]           accType,
  input  logic [NWIN-1:0]      addrMatch,
  input  logic [NWIN-1:0]      winEn,
  input  logic [NWIN-1:0][1:0] winProt,
  output win_strb_t            strb
);

  logic [NWIN-1:0] spaceOk;
  logic [NWIN-1:0] cand;
  logic [NWIN-1:0] refuse;
  logic [NWIN-1:0] winner;

  // address modifier to space
  always_comb begin
    spaceOk          = '0;
    spaceOk[WIN_A64] = (vmeAm == AM_A64_BLK);
    spaceOk[WIN_A32] = (vmeAm[5:3] == AM_A32_GRP);
    spaceOk[WIN_A24] = (vmeAm[5:3] == AM_A24_GRP);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign cand[w]   = spaceOk[w] & winEn[w] & addrMatch[w];
    assign refuse[w] = (winProt[w] == PROT_WR) ? (accType != ACC_READ)
                                               : (winProt[w] != PROT_NONE);
  end

  // highest index wins: 64-bit, then 32-bit, then 24-bit
  always_comb begin
    winner = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (cand[i]) winner = NWIN'(1) << i;
    end
  end

  always_comb begin
    strb.capture = cycleValid;
    strb.sel     = cycleValid ? (winner & ~refuse) : '0;
    strb.fault   = cycleValid & (|(winner & refuse));
  end

endmodule

// File: rtl/vme_win_dp.sv
module vme_win_dp
  import vme_win_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int A64_LOG     = 32,
  parameter int WIN_LOG     = 27,
  parameter int A32_W       = 32,
  parameter int A32_MIN_LOG = 12,
  parameter int A24_W       = 24,
  parameter int A24_MIN_LOG = 19,
  parameter int A24_SEL_W   = 2,
  parameter int LOG_W       = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           vmeAddr,
  input  logic [ADDR_W-A64_LOG-1:0]   a64BaseHi,
  input  logic [A32_W-WIN_LOG-1:0]    a32BaseHi,
  input  logic [LOG_W-1:0]            a32SizeLog,
  input  logic [A24_W-A24_MIN_LOG-1:0] a24BaseHi,
  input  logic [A24_SEL_W-1:0]        a24SizeSel,
  input  win_strb_t                   strb,
  output logic [NWIN-1:0]             addrMatch,
  output logic                        respValid,
  output logic [NWIN-1:0]             winSel,
  output logic [WIN_LOG-1:0]          localOffset,
  output logic                        protFault
);

  localparam int OFF_W = WIN_LOG;
  localparam int PAD_W = OFF_W - A24_W;

  logic [OFF_W-1:0] winOff [NWIN];
  logic [LOG_W-1:0] a32LogEff;
  logic [OFF_W-1:0] a32HiMask;
  logic [LOG_W-1:0] a24Log;
  logic [A24_W-1:0] a24HiMask;
  logic [A24_W-1:0] a24Base;
  logic [OFF_W-1:0] offNext;

  // 64-bit window: fixed 2^WIN_LOG bytes
  always_comb begin
    addrMatch[WIN_A64] = (vmeAddr[ADDR_W-1:A64_LOG] == a64BaseHi) &&
                         (vmeAddr[A64_LOG-1:WIN_LOG] == '0);
    winOff[WIN_A64]    = vmeAddr[WIN_LOG-1:0];
  end

  // 32-bit window: clamped power-of-two size at the bottom of its slot
  always_comb begin
    if (a32SizeLog < LOG_W'(A32_MIN_LOG))    a32LogEff = LOG_W'(A32_MIN_LOG);
    else if (a32SizeLog > LOG_W'(WIN_LOG))   a32LogEff = LOG_W'(WIN_LOG);
    else                                     a32LogEff = a32SizeLog;
    a32HiMask          = {OFF_W{1'b1}} << a32LogEff;
    addrMatch[WIN_A32] = (vmeAddr[A32_W-1:WIN_LOG] == a32BaseHi) &&
                         ((vmeAddr[WIN_LOG-1:0] & a32HiMask) == '0);
    winOff[WIN_A32]    = vmeAddr[WIN_LOG-1:0] & ~a32HiMask;
  end

  // 24-bit window: base bits under the size are dropped
  always_comb begin
    a24Log             = LOG_W'(A24_MIN_LOG) + LOG_W'(a24SizeSel);
    a24HiMask          = {A24_W{1'b1}} << a24Log;
    a24Base            = {a24BaseHi, {A24_MIN_LOG{1'b0}}};
    addrMatch[WIN_A24] = (((vmeAddr[A24_W-1:0] ^ a24Base) & a24HiMask) == '0);
    winOff[WIN_A24]    = {{PAD_W{1'b0}}, vmeAddr[A24_W-1:0] & ~a24HiMask};
  end

  always_comb begin
    offNext = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (strb.sel[i]) offNext = offNext | winOff[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      winSel      <= '0;
      localOffset <= '0;
      protFault   <= 1'b0;
    end else begin
      respValid <= strb.capture;
      if (strb.capture) begin
        winSel      <= strb.sel;
        localOffset <= offNext;
        protFault   <= strb.fault;
      end
    end
  end

endmodule

// File: rtl/vme_slave_win_dec.sv
module vme_slave_win_dec
  import vme_win_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int A64_LOG     = 32,
  parameter int WIN_LOG     = 27,
  parameter int A32_W       = 32,
  parameter int A32_MIN_LOG = 12,
  parameter int A24_W       = 24,
  parameter int A24_MIN_LOG = 19,
  parameter int A24_SEL_W   = 2,
  parameter int LOG_W       = $clog2(A32_W)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cycleValid,
  input  logic [ADDR_W-1:0]             vmeAddr,
  input  logic [5:0]                    vmeAm,
  input  logic [1:0]                    accType,
  input  logic                          a64En,
  input  logic [ADDR_W-A64_LOG-1:0]     a64BaseHi,
  input  logic [1:0]                    a64Prot,
  input  logic                          a32En,
  input  logic [A32_W-WIN_LOG-1:0]      a32BaseHi,
  input  logic [LOG_W-1:0]              a32SizeLog,
  input  logic [1:0]                    a32Prot,
  input  logic                          a24En,
  input  logic [A24_W-A24_MIN_LOG-1:0]  a24BaseHi,
  input  logic [A24_SEL_W-1:0]          a24SizeSel,
  input  logic [1:0]                    a24Prot,
  output logic                          respValid,
  output logic                          hit,
  output logic [NWIN-1:0]               winSel,
  output logic [WIN_LOG-1:0]            localOffset,
  output logic                          protFault
);

  win_strb_t            strb;
  logic [NWIN-1:0]      addrMatch;
  logic [NWIN-1:0]      winEn;
  logic [NWIN-1:0][1:0] winProt;

  assign winEn   = {a64En, a32En, a24En};
  assign winProt = {a64Prot, a32Prot, a24Prot};
  assign hit     = |winSel;

  vme_win_ctrl ctrl_i (
    .cycleValid (cycleValid),
    .vmeAm      (vmeAm),
    .accType    (accType),
    .addrMatch  (addrMatch),
    .winEn      (winEn),
    .winProt    (winProt),
    .strb       (strb)
  );

  vme_win_dp #(
    .ADDR_W(ADDR_W), .A64_LOG(A64_LOG), .WIN_LOG(WIN_LOG), .A32_W(A32_W),
    .A32_MIN_LOG(A32_MIN_LOG), .A24_W(A24_W), .A24_MIN_LOG(A24_MIN_LOG),
    .A24_SEL_W(A24_SEL_W), .LOG_W(LOG_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .vmeAddr     (vmeAddr),
    .a64BaseHi   (a64BaseHi),
    .a32BaseHi   (a32BaseHi),
    .a32SizeLog  (a32SizeLog),
    .a24BaseHi   (a24BaseHi),
    .a24SizeSel  (a24SizeSel),
    .strb        (strb),
    .addrMatch   (addrMatch),
    .respValid   (respValid),
    .winSel      (winSel),
    .localOffset (localOffset),
    .protFault   (protFault)
  );

endmodule

// File: rtl/vme_slave_win_dec_chk.sv
module vme_slave_win_dec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cycleValid,
  input logic [5:0]  vmeAm,
  input logic [1:0]  accType,
  input logic        a32En,
  input logic        a24En,
  input logic [1:0]  a32Prot,
  input logic        respValid,
  input logic        hit,
  input logic [2:0]  winSel,
  input logic [26:0] localOffset,
  input logic        protFault
);

  p_resp_next_r1: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |=> respValid);

  p_resp_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |=> !respValid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |=> ($stable(winSel) && $stable(localOffset) && $stable(protFault)));

  p_a64_blk_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && vmeAm != 6'h00) |=> !winSel[2]);

  p_miss_offset_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !hit) |-> (localOffset == '0));

  p_refused_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && accType != 2'd0 && a32Prot != 2'd0) |=> !winSel[1]);

  p_hit_fault_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && protFault));

  p_a32_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && !a32En) |=> !winSel[1]);

  p_a24_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && !a24En) |=> !winSel[0]);

  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winSel));

endmodule

bind vme_slave_win_dec vme_slave_win_dec_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cycleValid  (cycleValid),
  .vmeAm       (vmeAm),
  .accType     (accType),
  .a32En       (a32En),
  .a24En       (a24En),
  .a32Prot     (a32Prot),
  .respValid   (respValid),
  .hit         (hit),
  .winSel      (winSel),
  .localOffset (localOffset),
  .protFault   (protFault)
);

// File: tb/vme_slave_win_dec_tb_top.sv
module vme_slave_win_dec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleValid = 1'b0;
  logic [63:0] vmeAddr = '0;
  logic [5:0]  vmeAm = '0;
  logic [1:0]  accType = '0;
  logic        a64En = 1'b0, a32En = 1'b0, a24En = 1'b0;
  logic [31:0] a64BaseHi = '0;
  logic [4:0]  a32BaseHi = '0, a32SizeLog = '0, a24BaseHi = '0;
  logic [1:0]  a24SizeSel = '0;
  logic [1:0]  a64Prot = '0, a32Prot = '0, a24Prot = '0;
  logic        respValid, hit, protFault;
  logic [2:0]  winSel;
  logic [26:0] localOffset;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [63:0] lfsr = 64'hACE1_2468_9BDF_1357;

  always #5 clk = ~clk;

  vme_slave_win_dec dut_i (
    .clk(clk), .rstN(rstN), .cycleValid(cycleValid), .vmeAddr(vmeAddr),
    .vmeAm(vmeAm), .accType(accType),
    .a64En(a64En), .a64BaseHi(a64BaseHi), .a64Prot(a64Prot),
    .a32En(a32En), .a32BaseHi(a32BaseHi), .a32SizeLog(a32SizeLog), .a32Prot(a32Prot),
    .a24En(a24En), .a24BaseHi(a24BaseHi), .a24SizeSel(a24SizeSel), .a24Prot(a24Prot),
    .respValid(respValid), .hit(hit), .winSel(winSel),
    .localOffset(localOffset), .protFault(protFault)
  );

  function automatic logic [63:0] nextRand();
    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    return lfsr;
  endfunction

  // Reference: windows as numeric [start, start+size) ranges
  task automatic model(input logic [63:0] a, input logic [5:0] m, input logic [1:0] acc,
                       output logic [2:0] eSel, output logic [26:0] eOff, output logic eFault);
    longint unsigned st, sz, v;
    int w = -1;
    int lg;
    logic [1:0] p;
    eOff = '0;
    if (m == 6'h00 && a64En) begin
      st = {a64BaseHi, 32'h0};
      sz = 64'd1 << 27;
      if (a >= st && (a - st) < sz) begin w = 2; eOff = 27'(a - st); end
    end else if (m >= 6'h08 && m <= 6'h0F && a32En) begin
      lg = (a32SizeLog < 12) ? 12 : (a32SizeLog > 27) ? 27 : int'(a32SizeLog);
      st = longint'({a32BaseHi, 27'h0});
      sz = 64'd1 << lg;
      v  = longint'(a[31:0]);
      if (v >= st && (v - st) < sz) begin w = 1; eOff = 27'(v - st); end
    end else if (m >= 6'h38 && a24En) begin
      sz = 64'd1 << (19 + int'(a24SizeSel));
      st = (longint'(a24BaseHi) * 64'd524288 / sz) * sz;
      v  = longint'(a[23:0]);
      if (v >= st && (v - st) < sz) begin w = 0; eOff = 27'(v - st); end
    end
    eSel = '0;
    eFault = 1'b0;
    if (w >= 0) begin
      p = (w == 2) ? a64Prot : (w == 1) ? a32Prot : a24Prot;
      if (p >= 2 || (p == 1 && acc != 2'd0)) eFault = 1'b1;
      else eSel = 3'b001 << w;
    end
    if (eFault || eSel == 0) eOff = '0;
  endtask

  task automatic apply(input logic [63:0] a, input logic [5:0] m, input logic [1:0] acc,
                       input string req);
    logic [2:0] eSel;
    logic [26:0] eOff;
    logic eFault;
    model(a, m, acc, eSel, eOff, eFault);
    @(negedge clk);
    vmeAddr = a; vmeAm = m; accType = acc; cycleValid = 1'b1;
    @(negedge clk);
    cycleValid = 1'b0;
    nVec++;
    // R9: hit is the OR of the one-hot select
    if (respValid !== 1'b1 || winSel !== eSel || hit !== (|eSel) ||
        localOffset !== eOff || protFault !== eFault) begin
      nBad++;
      $display("FAIL %s (R9 hit/sel) addr=%h am=%h acc=%0d: got v=%b sel=%b hit=%b off=%h flt=%b exp v=1 sel=%b hit=%b off=%h flt=%b",
               req, a, m, acc, respValid, winSel, hit, localOffset, protFault,
               eSel, |eSel, eOff, eFault);
    end
  endtask

  // R1: idle cycle drops respValid and holds everything else
  task automatic idleCheck();
    logic [2:0] s; logic [26:0] o; logic f;
    s = winSel; o = localOffset; f = protFault;
    vmeAddr = nextRand(); vmeAm = 6'h09; accType = 2'd1;
    @(negedge clk);
    nVec++;
    if (respValid !== 1'b0 || winSel !== s || localOffset !== o || protFault !== f) begin
      nBad++;
      $display("FAIL R1 idle: got v=%b sel=%b off=%h flt=%b exp v=0 sel=%b off=%h flt=%b",
               respValid, winSel, localOffset, protFault, s, o, f);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    longint unsigned st, sz;
    repeat (3) @(negedge clk);
    // R10: reset state
    nVec++;
    if (respValid !== 0 || hit !== 0 || winSel !== 0 || localOffset !== 0 || protFault !== 0) begin
      nBad++;
      $display("FAIL R10 reset: got v=%b h=%b sel=%b off=%h f=%b exp all zero",
               respValid, hit, winSel, localOffset, protFault);
    end
    rstN = 1'b1;

    // R2: modifier sweep, address inside all three windows
    a64En = 1; a32En = 1; a24En = 1;
    a64BaseHi = 32'h1; a32BaseHi = 5'd0; a32SizeLog = 5'd27;
    a24BaseHi = 5'd0; a24SizeSel = 2'd0;
    for (int m = 0; m < 64; m++) begin
      for (int acc = 0; acc < 3; acc++) begin
        apply(64'h0000_0001_0000_1234, 6'(m), 2'(acc), "R2");
      end
    end
    idleCheck();

    // R5: 24-bit sizes, bases and window edges
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 32; b++) begin
        a24SizeSel = 2'(s); a24BaseHi = 5'(b);
        sz = 64'd1 << (19 + s);
        st = (longint'(b) * 64'd524288 / sz) * sz;
        r = nextRand();
        apply({r[63:24], 24'(st - 1)},        6'h3D, 2'd0, "R5");
        apply({r[63:24], 24'(st)},            6'h39, 2'd1, "R5");
        apply({r[63:24], 24'(st + sz - 1)},   6'h3E, 2'd2, "R5");
        apply({r[63:24], 24'(st + sz)},       6'h3A, 2'd0, "R5");
        apply({r[63:24], 24'(b * 524288)},    6'h3F, 2'd0, "R6");
        apply({r[63:24], 24'(st + (r[23:0] & 24'(sz - 1)))}, 6'h38, 2'd1, "R6");
      end
    end
    idleCheck();

    // R4: 32-bit size codes including clamp, bases and edges
    for (int lg = 0; lg < 32; lg++) begin
      for (int bi = 0; bi < 3; bi++) begin
        a32SizeLog = 5'(lg);
        a32BaseHi = (bi == 0) ? 5'd0 : (bi == 1) ? 5'd13 : 5'd31;
        st = longint'({a32BaseHi, 27'h0});
        sz = 64'd1 << ((lg < 12) ? 12 : (lg > 27) ? 27 : lg);
        r = nextRand();
        apply({r[63:32], 32'(st - 1)},      6'h09, 2'd0, "R4");
        apply({r[63:32], 32'(st)},          6'h0D, 2'd1, "R4");
        apply({r[63:32], 32'(st + sz - 1)}, 6'h0A, 2'd0, "R4");
        apply({r[63:32], 32'(st + sz)},     6'h0E, 2'd2, "R4");
        apply({r[63:32], 32'(st + (r[31:0] & 32'(sz - 1)))}, 6'h0B, 2'd0, "R6");
      end
    end
    idleCheck();

    // R3: 64-bit window edges, block-transfer modifier only
    for (int bi = 0; bi < 4; bi++) begin
      a64BaseHi = (bi == 0) ? 32'h0 : (bi == 1) ? 32'h1 : (bi == 2) ? 32'h8000_0000 : 32'hFFFF_FFFF;
      st = {a64BaseHi, 32'h0};
      r = nextRand();
      apply(st - 1,                         6'h00, 2'd0, "R3");
      apply(st,                             6'h00, 2'd1, "R3");
      apply(st + 64'h7FF_FFFF,              6'h00, 2'd0, "R3");
      apply(st + 64'h800_0000,              6'h00, 2'd0, "R3");
      apply(st + {37'h0, r[26:0]},          6'h00, 2'd0, "R6");
      apply(st + {37'h0, r[26:0]},          6'h01, 2'd0, "R3");
      apply(st + {37'h0, r[26:0]},          6'h03, 2'd0, "R3");
    end
    idleCheck();

    // R7: protection codes against access kinds in each window
    a64BaseHi = 32'h2; a32BaseHi = 5'd4; a32SizeLog = 5'd20; a24BaseHi = 5'd8; a24SizeSel = 2'd1;
    for (int p = 0; p < 4; p++) begin
      a64Prot = 2'(p); a32Prot = 2'(p); a24Prot = 2'(p);
      for (int acc = 0; acc < 4; acc++) begin
        apply(64'h0000_0002_0000_0040, 6'h00, 2'(acc), "R7");
        apply(64'h0000_0000_2000_0100, 6'h09, 2'(acc), "R7");
        apply(64'h0000_0000_0040_0200, 6'h3D, 2'(acc), "R7");
        idleCheck();
      end
    end
    a64Prot = 0; a32Prot = 0; a24Prot = 0;

    // R8: disabled windows stay silent, even with protection set
    for (int d = 0; d < 8; d++) begin
      a64En = d[0]; a32En = d[1]; a24En = d[2];
      a32Prot = 2'(d % 3);
      apply(64'h0000_0002_0000_0040, 6'h00, 2'd1, "R8");
      apply(64'h0000_0000_2000_0100, 6'h0D, 2'd1, "R8");
      apply(64'h0000_0000_0040_0200, 6'h39, 2'd0, "R8");
    end
    idleCheck();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule